// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block is the device-side end of a serial control port. A host reaches an internal register bank through three signals: an active-low chip select, a serial clock and one data line that both ends share. Every transaction opens with a 16-bit instruction and continues with whole data bytes. Both are sent most significant bit first. The instruction holds three fields, in this order from the first bit sent: a direction flag, a two-bit burst-length code and a 13-bit start address. Each later byte goes to the next address, produced by an internal counter that wraps at the top of the address space.

The serial inputs are oversampled by the system clock through a synchronizer. The block drives a plain parallel bank port: an address, write data, a one-cycle write strobe, and read data that the bank returns one system clock after the address. For the shared pin, the block drives an output value and an output enable. The pad itself sits outside the block. The serial clock half-period must be at least six system clock periods.

Top module: `spi3_regport`

## Requirements
- R1: After reset, `sdio_oe` and `reg_we` are low.
- R2: A transaction is recognised only while `cs_n` is low. Serial clock rises that occur while `cs_n` is high have no effect. The first 16 rising edges after `cs_n` falls capture the instruction MSB first: bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code, and bits 12:0 are the start address.
- R3: In a write, each group of 8 data bits, sampled MSB first on rising `sclk`, produces exactly one single-cycle `reg_we` pulse. That pulse carries the byte on `reg_wdata` and the byte's address on `reg_addr`. The first byte's address is the start address.
- R4: The address advances by one after every completed data byte and wraps from 0x1FFF to 0x0000.
- R5: Length code 00 allows 1 byte, 01 allows 2, 10 allows 3, and 11 places no limit until `cs_n` rises. Data bytes beyond the allowed count cause no write and are not driven on a read.
- R6: In a read, `sdio_oe` is high only during the allowed data bytes. `sdio_out` presents the byte that `reg_rdata` returns for the current address, MSB first, with each bit changing after a falling `sclk` edge.
- R7: A `cs_n` rise in the middle of a data byte discards that partial byte without a write. The next transaction then starts fresh with its instruction.
- R8: A `cs_n` rise in the middle of the instruction causes no write, and the next transaction decodes correctly.
- R9: `sdio_oe` stays low for the whole of a write transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from host |
| sclk | input | 1 | Serial clock from host |
| sdio_in | input | 1 | Data pin value seen at the pad |
| sdio_out | output | 1 | Value to drive onto the data pin |
| sdio_oe | output | 1 | Output enable for the data pin |
| reg_addr | output | 13 | Register bank address |
| reg_wdata | output | 8 | Register bank write data |
| reg_we | output | 1 | Register bank write strobe, one cycle |
| reg_rdata | input | 8 | Register bank read data, one cycle after address |

## Verification
The bench builds the block with its default values: a 13-bit address, 8-bit data and a two-stage synchronizer. The full 13-bit address space lets bursts that start at 0x1FFE cross the wrap point to 0x0000, in both write and read bursts. The 2-bit length code covers every fixed burst size and the unlimited size. Random bursts longer than their length code exercise the dropping of excess bytes. Aborts are placed inside the instruction and inside a data byte.

// File: rtl/spi3_pkg.sv
`timescale 1ns/1ps
package spi3_pkg;
  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_SKIP  = 2'd2
  } phase_t;

  localparam int LEN_W      = 2;
  localparam logic [LEN_W-1:0] LEN_STREAM = 2'b11;
endpackage

// File: rtl/spi3_sync.sv
`timescale 1ns/1ps
module spi3_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi3_frame.sv
`timescale 1ns/1ps
module spi3_frame
  import spi3_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              sdi,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              in_data,
  output logic              rd_mode,
  output logic              byte_start
);
  localparam int INSTR_W = ADDR_W + 1 + LEN_W;
  localparam int CNT_W   = $clog2(INSTR_W);
  localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(DATA_W - 1);

  logic [INSTR_W-2:0] sh;
  logic [INSTR_W-1:0] word;
  logic [CNT_W-1:0]   bit_cnt;
  logic [LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]   byte_cnt;
  logic               rw_q;
  logic               done_q;
  logic [ADDR_W-1:0]  cur_addr;
  phase_t             phase;

  assign word = {sh, sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      bit_cnt   <= '0;
      len_q     <= '0;
      byte_cnt  <= '0;
      rw_q      <= 1'b0;
      done_q    <= 1'b0;
      cur_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      phase     <= PH_INSTR;
    end else begin
      reg_we <= 1'b0;
      done_q <= 1'b0;
      if (done_q) cur_addr <= cur_addr + 1'b1;
      if (!cs_act) begin
        phase   <= PH_INSTR;
        bit_cnt <= '0;
      end else if (sck_rise) begin
        sh <= word[INSTR_W-2:0];
        case (phase)
          PH_INSTR: begin
            if (bit_cnt == INSTR_LAST) begin
              rw_q     <= word[INSTR_W-1];
              len_q    <= word[INSTR_W-2 -: LEN_W];
              cur_addr <= word[ADDR_W-1:0];
              byte_cnt <= '0;
              bit_cnt  <= '0;
              phase    <= PH_DATA;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (bit_cnt == BYTE_LAST) begin
              bit_cnt   <= '0;
              done_q    <= 1'b1;
              reg_we    <= !rw_q;
              reg_wdata <= word[DATA_W-1:0];
              byte_cnt  <= byte_cnt + 1'b1;
              if (len_q != LEN_STREAM && byte_cnt == len_q) phase <= PH_SKIP;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_addr   = cur_addr;
  assign in_data    = (phase == PH_DATA);
  assign rd_mode    = rw_q;
  assign byte_start = (bit_cnt == '0);

  // R3
  we_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1));

  // R7
  cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !reg_we);

  // R5
  skip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP && $past(phase) == PH_SKIP) |-> !reg_we);
endmodule

// File: rtl/spi3_rdshift.sv
`timescale 1ns/1ps
module spi3_rdshift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_fall,
  input  logic              in_data,
  input  logic              rd_mode,
  input  logic              byte_start,
  input  logic [DATA_W-1:0] rdata,
  output logic              sdo,
  output logic              oe
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
      oe <= 1'b0;
    end else begin
      oe <= cs_act & in_data & rd_mode;
      if (sck_fall && in_data && rd_mode)
        sh <= byte_start ? rdata : {sh[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo = sh[DATA_W-1];

  // R9
  oe_read_only_chk: assert property (@(posedge clk) disable iff (rst)
    oe |-> rd_mode);

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !oe);
endmodule

// File: rtl/spi3_regport.sv
`timescale 1ns/1ps
module spi3_regport #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int PIN_N = 3;

  logic [PIN_N-1:0] pins_s;
  logic s_cs_n, s_sck, s_sdi, sck_prev;
  logic sck_rise, sck_fall, cs_act;
  logic in_data, rd_mode, byte_start;

  spi3_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst(rst), .d({sdio_in, sclk, cs_n}), .q(pins_s)
  );

  assign s_cs_n = pins_s[0];
  assign s_sck  = pins_s[1];
  assign s_sdi  = pins_s[2];

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= s_sck;
  end

  assign sck_rise = s_sck & ~sck_prev;
  assign sck_fall = ~s_sck & sck_prev;
  assign cs_act   = ~s_cs_n;

  spi3_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_rise(sck_rise), .sdi(s_sdi),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .in_data(in_data), .rd_mode(rd_mode), .byte_start(byte_start)
  );

  spi3_rdshift #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_fall(sck_fall),
    .in_data(in_data), .rd_mode(rd_mode), .byte_start(byte_start),
    .rdata(reg_rdata), .sdo(sdio_out), .oe(sdio_oe)
  );
endmodule

// File: tb/tb_spi3_regport.sv
`timescale 1ns/1ps
module tb_spi3_regport;
  localparam int HALF = 80;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdio_in = 1'b0;
  logic sdio_out, sdio_oe, reg_we;
  logic [12:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata = 8'h00;

  int nchk = 0;
  int nerr = 0;
  int we_cnt = 0;
  int oe_bad = 0;
  logic [7:0] tx [8];
  logic [7:0] rx [8];
  logic [7:0] bank [int];
  logic [7:0] model [int];

  always #5 clk = ~clk;

  spi3_regport dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (!rst && reg_we) begin
      bank[int'(reg_addr)] = reg_wdata;
      we_cnt++;
    end
    reg_rdata <= bank.exists(int'(reg_addr)) ? bank[int'(reg_addr)] : 8'h00;
  end

  function automatic logic [7:0] peek_bank(input int a);
    return bank.exists(a) ? bank[a] : 8'h00;
  endfunction

  function automatic logic [7:0] peek_model(input int a);
    return model.exists(a) ? model[a] : 8'h00;
  endfunction

  function automatic int allowed(input logic [1:0] len, input int nb);
    if (len == 2'b11) return nb;
    return (nb < int'(len) + 1) ? nb : int'(len) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit rw, input logic [1:0] len, input logic [12:0] a,
                      input int nbytes, input int stop_bits);
    logic [15:0] ins;
    int total;
    ins = {rw, len, a};
    total = (stop_bits >= 0) ? stop_bits : 16 + 8 * nbytes;
    oe_bad = 0;
    cs_n = 1'b0;
    #HALF;
    for (int i = 0; i < total; i++) begin
      int bi;
      int bp;
      bit exp_oe;
      bi = (i - 16) / 8;
      bp = 7 - ((i - 16) % 8);
      if (i < 16) sdio_in = ins[15 - i];
      else if (!rw) sdio_in = tx[bi][bp];
      else sdio_in = 1'($urandom);
      #HALF;
      if (i >= 16) begin
        exp_oe = rw && (len == 2'b11 || bi <= int'(len));
        if (sdio_oe !== exp_oe) oe_bad++;
        if (rw) rx[bi][bp] = sdio_out;
      end else if (sdio_oe !== 1'b0) begin
        oe_bad++;
      end
      sclk = 1'b1;
      #HALF;
      sclk = 1'b0;
    end
    #HALF;
    cs_n = 1'b1;
    #(HALF * 3);
  endtask

  task automatic stray_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      sdio_in = 1'($urandom);
      #HALF; sclk = 1'b1; #HALF; sclk = 1'b0;
    end
    #HALF;
  endtask

  task automatic do_write(input logic [1:0] len, input logic [12:0] a, input int nb,
                          input string req);
    int w0;
    int eff;
    w0 = we_cnt;
    eff = allowed(len, nb);
    xfer(1'b0, len, a, nb, -1);
    for (int k = 0; k < eff; k++) model[int'(13'(a + 13'(k)))] = tx[k];
    chk(we_cnt - w0 == eff, req, we_cnt - w0, eff);
    chk(oe_bad == 0, "R9", oe_bad, 0);
    for (int k = 0; k < nb + 1; k++) begin
      int ad;
      ad = int'(13'(a + 13'(k)));
      chk(peek_bank(ad) == peek_model(ad), req, peek_bank(ad), peek_model(ad));
    end
  endtask

  task automatic do_read(input logic [1:0] len, input logic [12:0] a, input int nb,
                         input string req);
    int eff;
    eff = allowed(len, nb);
    xfer(1'b1, len, a, nb, -1);
    chk(oe_bad == 0, "R6 R5", oe_bad, 0);
    for (int k = 0; k < eff; k++) begin
      int ad;
      ad = int'(13'(a + 13'(k)));
      chk(rx[k] == peek_model(ad), req, rx[k], peek_model(ad));
    end
  endtask

  initial begin
    #2000000;
    nerr++;
    nchk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int w0;
    void'($urandom(32'h5EED));
    #2;
    repeat (5) #10;
    rst = 1'b0;
    #20;
    // R1
    chk(sdio_oe == 1'b0, "R1", sdio_oe, 0);
    chk(reg_we == 1'b0, "R1", reg_we, 0);

    // R2: stray clocks with select high, then a single-byte write
    w0 = we_cnt;
    stray_clocks(5);
    chk(we_cnt == w0, "R2", we_cnt - w0, 0);
    tx[0] = 8'hA5;
    do_write(2'b00, 13'h0010, 1, "R2 R3");

    // R4: burst across the wrap point
    tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33;
    do_write(2'b10, 13'h1FFE, 3, "R4");

    // R5: two-byte code with four bytes sent
    tx[0] = 8'h5A; tx[1] = 8'hC3; tx[2] = 8'hFF; tx[3] = 8'hEE;
    do_write(2'b01, 13'h0100, 4, "R5");

    // R6: streaming read across the wrap point
    do_read(2'b11, 13'h1FFE, 4, "R6 R4");
    // R5: single-byte read with extra clocks
    do_read(2'b00, 13'h0010, 3, "R5 R6");

    // R7: abort inside the second data byte of a stream
    tx[0] = 8'h77; tx[1] = 8'h99;
    w0 = we_cnt;
    xfer(1'b0, 2'b11, 13'h0040, 2, 16 + 8 + 5);
    model[32'h40] = 8'h77;
    chk(we_cnt - w0 == 1, "R7", we_cnt - w0, 1);
    chk(peek_bank(32'h41) == 8'h00, "R7", peek_bank(32'h41), 0);
    tx[0] = 8'h3C;
    do_write(2'b00, 13'h0041, 1, "R7");

    // R8: abort inside the instruction
    w0 = we_cnt;
    tx[0] = 8'hDE;
    xfer(1'b0, 2'b00, 13'h0020, 1, 10);
    chk(we_cnt == w0, "R8", we_cnt - w0, 0);
    chk(peek_bank(32'h20) == 8'h00, "R8", peek_bank(32'h20), 0);
    do_read(2'b01, 13'h0040, 2, "R8");

    // random bursts
    for (int t = 0; t < 36; t++) begin
      logic [12:0] a;
      logic [1:0] len;
      int nb;
      len = 2'($urandom);
      nb = 1 + int'($urandom % 5);
      a = ($urandom % 4 == 0) ? 13'(13'h1FFC + 13'($urandom % 4)) : 13'($urandom);
      for (int k = 0; k < 8; k++) tx[k] = 8'($urandom);
      if ($urandom % 2 == 0) do_write(len, a, nb, "R3 R5");
      else do_read(len, a, nb, "R6 R5");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule